// File: doc/BRIEF.md
# Masked-Load Function Command Register

This block holds the command word a disk controller receives from the host's I/O bus. Each write carries a nine-bit bus value and a merge mode. The value may replace the whole word, may only turn bits on where the bus carries 1, or may only turn bits off where the bus carries 0. Software can therefore change one field without reading the word back first.

The stored word is split into a unit select, a three-bit function code and two interrupt-disable flags. The bus encodes each flag active-low. A GO bit in the top position does not stay in the register. A write that leaves GO at 1 sends a single-cycle start pulse to the function sequencer. A synchronous clear command returns the function code to idle and leaves the other fields as they are.

Top module: `cmd_reg`

## Requirements
- R1: After reset the whole stored word is 0. This gives unit 0, function idle (code 0), both interrupt disables asserted and `go_pulse` low.
- R2: A write with `wr_mode` = 0 (full load) makes stored bits 7..0 equal to the bus bits 7..0, starting in the cycle after the write.
- R3: A write with `wr_mode` = 1 (set-ones) makes each stored bit the OR of its old value and the bus bit. Bits whose bus bit is 0 do not change.
- R4: A write with `wr_mode` = 2 (clear-zeros) makes each stored bit the AND of its old value and the bus bit. Bits whose bus bit is 1 do not change.
- R5: A write with `wr_mode` = 3 has no effect on any output.
- R6: `unit_sel` is stored bits 2..0. `func_code` is stored bits 5..3, with 0 idle, 1 read, 2 write, 3 recalibrate, 4 seek, 5 read-all, 6 write-all and 7 write-check.
- R7: `done_irq_dis` is the inverse of stored bit 6 and `attn_irq_dis` is the inverse of stored bit 7.
- R8: `go_pulse` is high for exactly the one cycle after a write whose merged bit 8 is 1. The stored GO is always taken as 0, so a clear-zeros write never starts the sequencer.
- R9: Once the pulse has ended, GO reads back as 0. `cmd_word[8]` equals `go_pulse`, and `cmd_word[7:0]` is the stored word.
- R10: `fn_clr` sets `func_code` to idle in the next cycle and keeps the other fields. Any write in the same cycle is discarded, and that write raises no GO pulse.
- R11: With no write and no clear, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_mode | input | 2 | Merge mode: 0 full, 1 set-ones, 2 clear-zeros, 3 none |
| wr_data | input | 9 | I/O bus bits 8..0 |
| fn_clr | input | 1 | Return function code to idle |
| unit_sel | output | 3 | Selected drive unit |
| func_code | output | 3 | Function code |
| done_irq_dis | output | 1 | Done/error interrupt disable |
| attn_irq_dis | output | 1 | Attention interrupt disable |
| go_pulse | output | 1 | One-cycle start to the sequencer |
| cmd_word | output | 9 | Readback of the word, GO in bit 8 |

## Verification
Every result of a write or a clear appears one cycle after the edge that takes the strobe. This covers the stored fields, their decoded outputs and the GO pulse. The pulse is low again one cycle after that. The bench drives at a falling edge and samples fields and pulse at the next falling edge, which is the first sample after the capturing edge. It then checks at the following falling edge that the pulse is gone. The sweep covers every bus value in every mode against several prior words, and each expected word is computed as a plain copy, OR or AND.

// File: rtl/cmd_reg_pkg.sv
// Shared types for the command register: write merge modes and function codes.
package cmd_reg_pkg;
    typedef enum logic [1:0] {
        MODE_FULL = 2'd0,
        MODE_SET  = 2'd1,
        MODE_CLR  = 2'd2,
        MODE_NONE = 2'd3
    } wr_mode_e;

    localparam logic [2:0] FN_IDLE     = 3'd0;
    localparam logic [2:0] FN_READ     = 3'd1;
    localparam logic [2:0] FN_WRITE    = 3'd2;
    localparam logic [2:0] FN_RECAL    = 3'd3;
    localparam logic [2:0] FN_SEEK     = 3'd4;
    localparam logic [2:0] FN_READALL  = 3'd5;
    localparam logic [2:0] FN_WRITEALL = 3'd6;
    localparam logic [2:0] FN_WCHECK   = 3'd7;
endpackage

// File: rtl/cmd_merge.sv
// Per-bit merge of the bus value into the current word.
// Assumes: mode is a wr_mode_e; MODE_NONE returns the current word unchanged.
module cmd_merge
    import cmd_reg_pkg::*;
#(
    parameter int W = 9
) (
    input  wr_mode_e       mode,
    input  logic [W-1:0]   bus,
    input  logic [W-1:0]   cur,
    output logic [W-1:0]   nxt
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            // Select copy, OR-in or AND-in for this bit.
            always_comb begin
                unique case (mode)
                    MODE_FULL: nxt[i] = bus[i];
                    MODE_SET:  nxt[i] = cur[i] | bus[i];
                    MODE_CLR:  nxt[i] = cur[i] & bus[i];
                    default:   nxt[i] = cur[i];
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/cmd_store.sv
// Holds the stored fields (everything below GO).
// Assumes: clr has priority over wr and affects only the function field.
module cmd_store #(
    parameter int W        = 8,
    parameter int FUNC_LSB = 3,
    parameter int FUNC_W   = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Update the stored word on reset, clear or write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (clr)
            q[FUNC_LSB +: FUNC_W] <= '0;
        else if (wr)
            q <= d;
    end
endmodule

// File: rtl/cmd_go.sv
// Produces the one-cycle start pulse from the merged GO bit.
// Assumes: the stored GO is always 0, so only a write can raise it.
module cmd_go (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic clr,
    input  logic go_bit,
    output logic go_pulse
);
    // Register the pulse for one cycle; a clear suppresses it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            go_pulse <= 1'b0;
        else
            go_pulse <= wr && !clr && go_bit;
    end
endmodule

// File: rtl/cmd_reg.sv
// Masked-load command register: merge, store, decode, start pulse.
// Assumes: wr_en is a single-cycle strobe; bus layout is unit, function,
// done-enable, attention-enable, GO from bit 0 upward.
module cmd_reg
    import cmd_reg_pkg::*;
#(
    parameter int UNIT_W = 3,
    parameter int FUNC_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                wr_mode,
    input  logic [UNIT_W+FUNC_W+2:0]  wr_data,
    input  logic                      fn_clr,
    output logic [UNIT_W-1:0]         unit_sel,
    output logic [FUNC_W-1:0]         func_code,
    output logic                      done_irq_dis,
    output logic                      attn_irq_dis,
    output logic                      go_pulse,
    output logic [UNIT_W+FUNC_W+2:0]  cmd_word
);
    localparam int CMD_W    = UNIT_W + FUNC_W + 3;
    localparam int FUNC_LSB = UNIT_W;
    localparam int DONE_POS = UNIT_W + FUNC_W;
    localparam int ATTN_POS = DONE_POS + 1;
    localparam int GO_POS   = CMD_W - 1;

    logic [CMD_W-2:0] stored;
    logic [CMD_W-1:0] merged;
    wr_mode_e         mode;

    assign mode = wr_mode_e'(wr_mode);

    cmd_merge #(.W(CMD_W)) u_merge (
        .mode (mode),
        .bus  (wr_data),
        .cur  ({1'b0, stored}),
        .nxt  (merged)
    );

    cmd_store #(.W(CMD_W-1), .FUNC_LSB(FUNC_LSB), .FUNC_W(FUNC_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_en),
        .clr   (fn_clr),
        .d     (merged[CMD_W-2:0]),
        .q     (stored)
    );

    cmd_go u_go (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_en),
        .clr      (fn_clr),
        .go_bit   (merged[GO_POS]),
        .go_pulse (go_pulse)
    );

    assign unit_sel     = stored[UNIT_W-1:0];
    assign func_code    = stored[FUNC_LSB +: FUNC_W];
    assign done_irq_dis = ~stored[DONE_POS];
    assign attn_irq_dis = ~stored[ATTN_POS];
    assign cmd_word     = {go_pulse, stored};
endmodule

// File: rtl/cmd_reg_chk.sv
// Temporal checks on the command register ports, bound to cmd_reg.
module cmd_reg_chk #(
    parameter int CMD_W = 9,
    parameter int FUNC_LSB = 3,
    parameter int FUNC_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_mode,
    input logic [CMD_W-1:0] wr_data,
    input logic             fn_clr,
    input logic             go_pulse,
    input logic [CMD_W-1:0] cmd_word
);
    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        go_pulse |=> !go_pulse); // R9
    AST_GO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        go_pulse |-> $past(wr_en) && $past(wr_data[CMD_W-1]) && !$past(fn_clr)); // R8
    AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        fn_clr |=> cmd_word[FUNC_LSB +: FUNC_W] == '0 && !go_pulse); // R10
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !fn_clr) |=> $stable(cmd_word[CMD_W-2:0])); // R11
    AST_NONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mode == 2'd3 && !fn_clr) |=> $stable(cmd_word[CMD_W-2:0]) && !go_pulse); // R5
    AST_FULL_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mode == 2'd0 && !fn_clr) |=> cmd_word[CMD_W-2:0] == $past(wr_data[CMD_W-2:0])); // R2
    AST_SET_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mode == 2'd1 && !fn_clr) |=>
        (cmd_word[CMD_W-2:0] & $past(cmd_word[CMD_W-2:0])) == $past(cmd_word[CMD_W-2:0])); // R3
    AST_CLR_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mode == 2'd2 && !fn_clr) |=>
        (cmd_word[CMD_W-2:0] | $past(cmd_word[CMD_W-2:0])) == $past(cmd_word[CMD_W-2:0]) && !go_pulse); // R4
endmodule

bind cmd_reg cmd_reg_chk #(.CMD_W(CMD_W), .FUNC_LSB(FUNC_LSB), .FUNC_W(FUNC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_mode  (wr_mode),
    .wr_data  (wr_data),
    .fn_clr   (fn_clr),
    .go_pulse (go_pulse),
    .cmd_word (cmd_word)
);

// File: tb/cmd_reg_tb.sv
// Exhaustive sweep of bus values and modes against several prior words.
module cmd_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_mode = 2'd0;
    logic [8:0] wr_data = '0;
    logic       fn_clr = 1'b0;
    logic [2:0] unit_sel, func_code;
    logic       done_irq_dis, attn_irq_dis, go_pulse;
    logic [8:0] cmd_word;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cmd_reg u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode),
        .wr_data(wr_data), .fn_clr(fn_clr), .unit_sel(unit_sel),
        .func_code(func_code), .done_irq_dis(done_irq_dis),
        .attn_irq_dis(attn_irq_dis), .go_pulse(go_pulse), .cmd_word(cmd_word)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare all decoded outputs against an expected stored word.
    task automatic check_word(input string req, input logic [7:0] w);
        check(req, int'(cmd_word[7:0]), int'(w));
        check({req, "/R6 unit"}, int'(unit_sel), int'(w[2:0]));
        check({req, "/R6 func"}, int'(func_code), int'(w[5:3]));
        check({req, "/R7 done"}, int'(done_irq_dis), int'(!w[6]));
        check({req, "/R7 attn"}, int'(attn_irq_dis), int'(!w[7]));
    endtask

    // Drive one write; returns after the first sample following capture.
    task automatic do_write(input logic [1:0] m, input logic [8:0] d, input logic c);
        @(negedge clk);
        wr_en = 1'b1; wr_mode = m; wr_data = d; fn_clr = c;
        @(negedge clk);
        wr_en = 1'b0; fn_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] priors [8];
        priors = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h0F, 8'hF0, 8'h3C, 8'hC3};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_word("R1", 8'h00);
        check("R1 go", int'(go_pulse), 0);

        for (int p = 0; p < 8; p++) begin
            for (int m = 0; m < 4; m++) begin
                for (int v = 0; v < 512; v++) begin
                    logic [7:0] pw, ew;
                    logic       eg;
                    string      rq;
                    pw = priors[p];
                    do_write(2'd0, {1'b0, pw}, 1'b0);
                    do_write(2'(m), 9'(v), 1'b0);
                    case (m)
                        0: begin ew = v[7:0];      eg = v[8]; rq = "R2"; end
                        1: begin ew = pw | v[7:0]; eg = v[8]; rq = "R3"; end
                        2: begin ew = pw & v[7:0]; eg = 1'b0; rq = "R4"; end
                        default: begin ew = pw;    eg = 1'b0; rq = "R5"; end
                    endcase
                    check_word(rq, ew);
                    check("R8 go pulse", int'(go_pulse), int'(eg));
                    check("R9 readback go", int'(cmd_word[8]), int'(eg));
                    @(negedge clk);
                    check("R9 go gone", int'(cmd_word[8]), 0);
                    check_word("R11 hold", ew);
                end
            end
        end

        // R10: clear with a concurrent GO write keeps other fields
        do_write(2'd0, 9'h0EB, 1'b0);          // unit 3, func 5, both enables set
        @(negedge clk);
        do_write(2'd0, 9'h100, 1'b1);
        check_word("R10 clear", 8'hC3);
        check("R10 no go", int'(go_pulse), 0);
        do_write(2'd1, 9'h038, 1'b0);          // func 7 via set-ones
        check("R6 wcheck code", int'(func_code), 7);
        do_write(2'd2, 9'h1C7, 1'b1);          // clear wins over clear-zeros write
        check_word("R10 clear2", 8'hC3);
        finish_run();
    end
endmodule